// File: doc/BRIEF.md
# Eight-Channel Phase-Programmable LO Divider Bank

The block generates in-phase and quadrature local-oscillator square waves for eight mixer channels. It divides a fast reference clock down to the LO rate. Each channel gets its own phase offset and can be switched off on its own. The mixer downstream uses the per-channel I and Q levels as enables. The reference clock is the block clock `clk`.

A 40-bit serial chain holds a phase code and a shutdown bit for every channel. Software shifts the chain in one bit per clock while `cfg_shift` is high. A pulse on `cfg_load` then copies the chain into a pending copy. Each channel moves the pending settings into its working settings only when its own counter wraps, so an output never glitches.

Two mode pins set the divide ratio and the clock source:
- divide by 16 with a phase resolution of one count in sixteen;
- divide by 8;
- divide by 4, where each channel counts only on its own tick input;
- bypass, where externally formed I and Q levels pass through.

Top module: `lo_phase_divider_bank`

## Requirements
- R1: While `rst_n` is low, every output is low and every counter is zero. After reset every channel is shut down and stays shut down until a configuration reaches it. Its working settings and the pending copy both reset to phase 0 with the shutdown bit set.
- R2: The chain is 40 bits long and takes in `cfg_sdi` on each clock with `cfg_shift` high. Channel 7 is shifted first and channel 0 last. Within a channel the five bits arrive as phase bit 3 (MSB), bit 2, bit 1, bit 0, then the shutdown bit. After 40 shifts, channel c holds its phase in chain bits [5c+4:5c+1] and its shutdown bit in chain bit 5c.
- R3: A clock with `cfg_load` high copies the chain into the pending copy. A channel loads the pending copy into its working settings only on the clock where its counter wraps from N-1 to 0. Before that clock, its outputs keep following the old settings.
- R4: `mode_sel` = 00 selects divide by 16. Every counter advances on every clock, modulo 16, and all counters share a common zero from reset. `lo_i[c]` is high exactly when (count − phase) mod N < N/2. Outputs are registered: the value seen after a clock edge reflects the count and settings held before that edge.
- R5: `lo_q[c]` is the I waveform shifted by a quarter period. It is high exactly when (count − phase − N/4) mod N < N/2.
- R6: `mode_sel` = 01 selects divide by 8. The counter runs modulo 8 and the phase MSB is ignored.
- R7: `mode_sel` = 10 selects divide by 4. Channel c's counter advances only on clocks with `ch_tick[c]` high, modulo 4. The two upper phase bits are ignored.
- R8: `mode_sel` = 11 selects bypass. `lo_i` and `lo_q` take the values of `ext_i` and `ext_q` from the previous clock, whatever the chain, the pending copy or the shutdown bits hold.
- R9: Outside bypass, a channel whose working shutdown bit is 1 holds both of its outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Operating mode: 00 div16, 01 div8, 10 div4 with per-channel ticks, 11 bypass |
| cfg_sdi | input | 1 | Serial configuration data |
| cfg_shift | input | 1 | Shift enable for the configuration chain |
| cfg_load | input | 1 | Copies the chain into the pending copy |
| ch_tick | input | 8 | Per-channel count enables, used in divide-by-4 mode |
| ext_i | input | 8 | Externally formed I levels for bypass mode |
| ext_q | input | 8 | Externally formed Q levels for bypass mode |
| lo_i | output | 8 | Per-channel in-phase LO enable |
| lo_q | output | 8 | Per-channel quadrature LO enable |

## Verification
The assertions assume that `mode_sel` changes only while `rst_n` is low. The counter-range and bypass-follow properties depend on that, because a live mode change could leave a counter above its new modulus. The bench therefore sets the mode only inside reset. It never raises `cfg_shift` and `cfg_load` in the same clock. It drives every input on the falling edge, so the design samples stable values.

// File: rtl/lo_div_pkg.sv
package lo_div_pkg;

    typedef enum logic [1:0] {
        MODE_DIV16  = 2'b00,
        MODE_DIV8   = 2'b01,
        MODE_DIV4   = 2'b10,
        MODE_BYPASS = 2'b11
    } lo_mode_e;

    // log2 of the counter modulus for a mode; bypass keeps the full range
    function automatic int unsigned lo_log2n(lo_mode_e m, int unsigned ph_bits);
        if (m == MODE_BYPASS) return ph_bits;
        return ph_bits - int'(m);
    endfunction

endpackage

// File: rtl/lo_cfg_chain.sv
module lo_cfg_chain #(
    parameter int NUM_CH  = 8,
    parameter int PH_BITS = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_sdi,
    input  logic                              cfg_shift,
    input  logic                              cfg_load,
    output logic [NUM_CH*(PH_BITS+1)-1:0]     pend_cfg
);
    localparam int CFG_W   = PH_BITS + 1;
    localparam int CHAIN_W = NUM_CH * CFG_W;

    function automatic logic [CHAIN_W-1:0] pend_reset_value();
        logic [CHAIN_W-1:0] v;
        v = '0;
        for (int c = 0; c < NUM_CH; c++) v[c*CFG_W] = 1'b1;
        return v;
    endfunction

    localparam logic [CHAIN_W-1:0] PEND_RST = pend_reset_value();

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
        logic [CHAIN_W-1:0] pend;
    } chain_st_t;

    chain_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_shift) st_d.chain = {st_q.chain[CHAIN_W-2:0], cfg_sdi};
        if (cfg_load)  st_d.pend  = st_q.chain;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= '0;
            st_q.pend  <= PEND_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_cfg = st_q.pend;

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |=> (st_q.chain[0] == $past(cfg_sdi))); // R2
    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_shift |=> $stable(st_q.chain)); // R2
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(st_q.pend)); // R3

endmodule

// File: rtl/lo_chan_div.sv
module lo_chan_div
    import lo_div_pkg::*;
#(
    parameter int PH_BITS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_sel,
    input  logic               tick,
    input  logic               ext_i,
    input  logic               ext_q,
    input  logic [PH_BITS:0]   pend_cfg,
    output logic               lo_i,
    output logic               lo_q
);
    localparam int CFG_W = PH_BITS + 1;

    typedef struct packed {
        logic [PH_BITS-1:0] cnt;
        logic [CFG_W-1:0]   act;
        logic               i;
        logic               q;
    } chan_st_t;

    chan_st_t           st_d, st_q;
    lo_mode_e           mode;
    int unsigned        log2n;
    logic [PH_BITS-1:0] mask, half_n, quarter_n, phase, rel_i, rel_q;
    logic               adv, wrap, sd;

    assign mode = lo_mode_e'(mode_sel);

    always_comb begin
        st_d      = st_q;
        log2n     = lo_log2n(mode, PH_BITS);
        mask      = PH_BITS'((32'd1 << log2n) - 32'd1);
        half_n    = PH_BITS'(32'd1 << (log2n - 1));
        quarter_n = PH_BITS'(32'd1 << (log2n - 2));
        phase     = st_q.act[CFG_W-1:1] & mask;
        sd        = st_q.act[0];
        rel_i     = (st_q.cnt - phase) & mask;
        rel_q     = (st_q.cnt - phase - quarter_n) & mask;
        adv       = (mode == MODE_DIV4) ? tick : 1'b1;
        wrap      = adv && (st_q.cnt == mask);

        if (wrap)     st_d.cnt = '0;
        else if (adv) st_d.cnt = st_q.cnt + 1'b1;

        if (wrap) st_d.act = pend_cfg;

        if (mode == MODE_BYPASS) begin
            st_d.i = ext_i;
            st_d.q = ext_q;
        end else begin
            st_d.i = !sd && (rel_i < half_n);
            st_d.q = !sd && (rel_q < half_n);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.act <= CFG_W'(1);
            st_q.i   <= 1'b0;
            st_q.q   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_i = st_q.i;
    assign lo_q = st_q.q;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.cnt & ~mask) == '0)); // R6
    AST_CFG_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(st_q.act)); // R3
    AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DIV4 && !tick) |=> $stable(st_q.cnt)); // R7
    AST_SD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_BYPASS && st_q.act[0]) |=> (!lo_i && !lo_q)); // R9
    AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BYPASS) |=> (lo_i == $past(ext_i) && lo_q == $past(ext_q))); // R8

endmodule

// File: rtl/lo_phase_divider_bank.sv
module lo_phase_divider_bank #(
    parameter int NUM_CH  = 8,
    parameter int PH_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              cfg_sdi,
    input  logic              cfg_shift,
    input  logic              cfg_load,
    input  logic [NUM_CH-1:0] ch_tick,
    input  logic [NUM_CH-1:0] ext_i,
    input  logic [NUM_CH-1:0] ext_q,
    output logic [NUM_CH-1:0] lo_i,
    output logic [NUM_CH-1:0] lo_q
);
    localparam int CFG_W   = PH_BITS + 1;
    localparam int CHAIN_W = NUM_CH * CFG_W;

    logic [CHAIN_W-1:0] pend_cfg;

    lo_cfg_chain #(.NUM_CH(NUM_CH), .PH_BITS(PH_BITS)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_sdi   (cfg_sdi),
        .cfg_shift (cfg_shift),
        .cfg_load  (cfg_load),
        .pend_cfg  (pend_cfg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        lo_chan_div #(.PH_BITS(PH_BITS)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_sel (mode_sel),
            .tick     (ch_tick[c]),
            .ext_i    (ext_i[c]),
            .ext_q    (ext_q[c]),
            .pend_cfg (pend_cfg[c*CFG_W +: CFG_W]),
            .lo_i     (lo_i[c]),
            .lo_q     (lo_q[c])
        );
    end

endmodule

// File: tb/lo_phase_divider_bank_bench.sv
module lo_phase_divider_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic cfg_sdi = 1'b0, cfg_shift = 1'b0, cfg_load = 1'b0;
    logic [NCH-1:0] ch_tick = '0, ext_i = '0, ext_q = '0;
    logic [NCH-1:0] lo_i, lo_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    lo_phase_divider_bank u_lo_phase_divider_bank (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .cfg_sdi(cfg_sdi), .cfg_shift(cfg_shift), .cfg_load(cfg_load),
        .ch_tick(ch_tick), .ext_i(ext_i), .ext_q(ext_q),
        .lo_i(lo_i), .lo_q(lo_q)
    );

    int n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    logic [15:0] q_exp[$];
    string q_tag[$];
    logic [15:0] lfsr = 16'hACE1;

    // reference state, built from the requirements
    logic [39:0] m_chain, m_pend;
    logic [3:0]  m_cnt [NCH];
    logic [4:0]  m_act [NCH];

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic lvl(input int cnt, input int ph, input int off, input int n);
        int rel;
        rel = (cnt - ph - off + 3*n) % n;
        return rel < n/2;
    endfunction

    // model: pushes the expected outputs after every rising edge
    always @(posedge clk) begin
        logic [7:0] ei, eq;
        if (!rst_n) begin
            m_chain = '0;
            m_pend  = '0;
            for (int c = 0; c < NCH; c++) begin
                m_pend[c*5] = 1'b1;
                m_cnt[c] = '0;
                m_act[c] = 5'b00001;
            end
            ei = '0; eq = '0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                int n, ph;
                logic adv, wr;
                n  = (mode_sel == 2'b11) ? 16 : (16 >> mode_sel);
                ph = int'(m_act[c][4:1]) % n;
                if (mode_sel == 2'b11) begin
                    ei[c] = ext_i[c]; eq[c] = ext_q[c];
                end else begin
                    ei[c] = !m_act[c][0] && lvl(int'(m_cnt[c]), ph, 0, n);
                    eq[c] = !m_act[c][0] && lvl(int'(m_cnt[c]), ph, n/4, n);
                end
                adv = (mode_sel == 2'b10) ? ch_tick[c] : 1'b1;
                wr  = adv && (int'(m_cnt[c]) == n-1);
                if (wr) begin
                    m_cnt[c] = '0;
                    m_act[c] = m_pend[c*5 +: 5];
                end else if (adv) m_cnt[c] = m_cnt[c] + 4'd1;
            end
            if (cfg_load)  m_pend  = m_chain;
            if (cfg_shift) m_chain = {m_chain[38:0], cfg_sdi};
        end
        q_exp.push_back({ei, eq});
        q_tag.push_back(cur_req);
    end

    // monitor: pops and compares away from the edge
    initial forever begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (q_exp.size() > 0) begin
            logic [15:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check(t, {lo_i, lo_q}, e);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic run(input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ch_tick = lfsr[7:0];
            ext_i   = lfsr[15:8];
            ext_q   = lfsr[11:4];
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 1'b0;
        mode_sel = m;
        cur_req = "R1";
        run(3);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load_cfg(input logic [39:0] word);
        for (int b = 39; b >= 0; b--) begin
            @(negedge clk);
            cfg_sdi = word[b];
            cfg_shift = 1'b1;
        end
        @(negedge clk);
        cfg_shift = 1'b0;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    function automatic logic [39:0] make_cfg(input int seed, input int sd_ch);
        logic [39:0] w;
        for (int c = 0; c < NCH; c++) begin
            w[c*5+1 +: 4] = 4'((c*seed + 3) % 16);
            w[c*5] = (c == sd_ch);
        end
        return w;
    endfunction

    initial begin
        do_reset(2'b00);
        // R1: all channels stay off after reset
        run(20);
        check("R1", {lo_i, lo_q}, 16'h0000);

        cur_req = "R2,R4,R5";
        load_cfg(make_cfg(5, 3));
        run(70);
        // R9: channel 3 carries the shutdown bit
        for (int k = 0; k < 16; k++) begin
            @(posedge clk); #(CLK_PERIOD/4);
            check("R9", {7'b0, lo_i[3], 7'b0, lo_q[3]}, 16'h0000);
        end

        cur_req = "R3";
        load_cfg(make_cfg(7, 9));
        run(60);

        do_reset(2'b01);
        cur_req = "R6";
        load_cfg(make_cfg(11, 9) | 40'h8_4210_8421 << 4);
        run(60);

        do_reset(2'b10);
        cur_req = "R7";
        load_cfg(make_cfg(13, 5));
        run(120);

        do_reset(2'b11);
        cur_req = "R8";
        load_cfg(make_cfg(3, 0));
        run(60);

        run(2);
        finish_run();
    end

endmodule